// File: doc/BRIEF.md
# Fractional-Duty Timer PWM Generator

This block drives one PWM output from a free-running system clock. A prescaler divides the clock by 1, 4 or 16. Each prescaled step advances a two-bit quarter-phase counter. Each full turn of that counter advances an 8-bit period timer. A period ends once the timer has reached the programmed period byte and the quarter phase has reached its last step. At that point a new period starts and both counters return to zero.

The on time comes from a 10-bit duty word. The duty high byte forms its upper bits and two separate duty low bits form its lower bits. The output is driven high at the start of a period. It falls when the combined position {timer, quarter phase} reaches the duty word. This gives duty steps four times finer than the period timer. All configuration inputs are captured only at a period start, so they can be changed at any time without a malformed pulse.

Top module: `pwm_frac_gen`

## Requirements
- R1: With prescale factor P and period byte N, one PWM period lasts exactly (N+1)*4*P system clocks.
- R2: The prescaler select maps 0 to a factor of 1, 1 to a factor of 4, and both 2 and 3 to a factor of 16.
- R3: The duty word is {duty high byte, duty low bits}, with the low bits in the two least significant positions. For a duty word D with 0 < D < 4*(N+1), the output is high for exactly D*P clocks at the start of each period and low for the rest of that period.
- R4: If D is at least 4*(N+1), the output stays high continuously, period after period. At D = 4*(N+1)-1 the output still has a low phase of exactly P clocks.
- R5: If D is zero, the output stays low continuously.
- R6: The output rises only at a period start. The first period starts on the first clock edge at which enable is seen high, so the output is high on the cycle after that edge.
- R7: Period, duty and prescaler inputs are taken in only at a period start. A change in the middle of a period leaves the running period unchanged and takes effect from the next one.
- R8: While enable is low, the output is low from the cycle after the edge at which enable is sampled low, and all counters sit at zero. After enable returns high, the first period therefore has its full length.
- R9: After reset, the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the block idle |
| periodIn | input | 8 | Period byte N |
| dutyHiIn | input | 8 | Duty high byte (upper eight bits of D) |
| dutyLoIn | input | 2 | Duty low bits (lower two bits of D) |
| preSel | input | 2 | Prescaler select |
| pwmOut | output | 1 | Registered PWM output |

## Verification
The output is registered, so every effect appears one cycle after the clock edge that causes it. Enabling the block shows a high output on the first cycle after the enabling edge. Dropping enable shows a low output one cycle later. A period change or duty change shows up only in the first full period that starts after the write. The bench drives inputs and samples the output on the falling clock edge, so each sample reads the value settled after the preceding rising edge. Each pulse is measured by counting falling-edge samples from one rise of the output to the next: the high count must be D*P and the total count (N+1)*4*P. The mid-period write test checks both the period that is running and the one after it.

// File: rtl/pwm_frac_pkg.sv
`timescale 1ns/1ps
package pwm_frac_pkg;

  // Strobes from the control unit to the datapath; at most one is set per cycle.
  typedef struct packed {
    logic start;  // begin a new period: capture inputs, zero the counters
    logic adv;    // advance the quarter-phase position by one
    logic clear;  // idle: zero everything, output low
  } pwm_strobe_t;

  // Terminal count of the prescaler for a given select code.
  function automatic logic [3:0] preLimit(input logic [1:0] sel);
    case (sel)
      2'd0:    preLimit = 4'd0;   // divide by 1
      2'd1:    preLimit = 4'd3;   // divide by 4
      default: preLimit = 4'd15;  // divide by 16
    endcase
  endfunction

endpackage

// File: rtl/pwm_frac_ctrl.sv
`timescale 1ns/1ps
module pwm_frac_ctrl
  import pwm_frac_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        en,
  input  logic [1:0]  preSel,
  input  logic        atLastPos,
  output pwm_strobe_t strb
);

  typedef enum logic {ST_IDLE, ST_RUN} ctrl_state_t;

  ctrl_state_t      state;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLim;
  logic             quarterWrap;

  // A prescaled step completes when the divider reaches its limit.
  assign quarterWrap = (state == ST_RUN) && (preCnt == preLim);

  always_comb begin
    strb.clear = !en;
    strb.start = en && ((state == ST_IDLE) || (quarterWrap && atLastPos));
    strb.adv   = en && quarterWrap && !strb.start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      preCnt <= '0;
      preLim <= '0;
    end else if (!en) begin
      state  <= ST_IDLE;
      preCnt <= '0;
    end else if (strb.start) begin
      state  <= ST_RUN;
      preCnt <= '0;
      preLim <= PRE_W'(preLimit(preSel));
    end else if (state == ST_RUN) begin
      preCnt <= quarterWrap ? '0 : preCnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_frac_datapath.sv
`timescale 1ns/1ps
module pwm_frac_datapath
  import pwm_frac_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwm_strobe_t       strb,
  input  logic [TMR_W-1:0]  periodIn,
  input  logic [TMR_W-1:0]  dutyHiIn,
  input  logic [FRAC_W-1:0] dutyLoIn,
  output logic              atLastPos,
  output logic              pwmOut
);

  localparam int POS_W = TMR_W + FRAC_W;

  logic [TMR_W-1:0]  perShadow;
  logic [POS_W-1:0]  dutyShadow;
  logic [TMR_W-1:0]  tmrCnt;
  logic [FRAC_W-1:0] subCnt;
  logic [POS_W-1:0]  nextPos;
  logic [POS_W-1:0]  dutyWord;
  logic              pwmQ;

  assign dutyWord  = {dutyHiIn, dutyLoIn};
  assign nextPos   = {tmrCnt, subCnt} + 1'b1;
  assign atLastPos = (tmrCnt == perShadow) && (subCnt == {FRAC_W{1'b1}});
  assign pwmOut    = pwmQ;

  // Configuration is captured only at a period boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perShadow  <= '0;
      dutyShadow <= '0;
    end else if (strb.start) begin
      perShadow  <= periodIn;
      dutyShadow <= dutyWord;
    end
  end

  // Position counters and output register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
      subCnt <= '0;
      pwmQ   <= 1'b0;
    end else if (strb.clear) begin
      tmrCnt <= '0;
      subCnt <= '0;
      pwmQ   <= 1'b0;
    end else if (strb.start) begin
      tmrCnt <= '0;
      subCnt <= '0;
      pwmQ   <= (dutyWord != '0);
    end else if (strb.adv) begin
      {tmrCnt, subCnt} <= nextPos;
      if (nextPos == dutyShadow) pwmQ <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_frac_gen.sv
`timescale 1ns/1ps
module pwm_frac_gen
  import pwm_frac_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [TMR_W-1:0]  periodIn,
  input  logic [TMR_W-1:0]  dutyHiIn,
  input  logic [FRAC_W-1:0] dutyLoIn,
  input  logic [1:0]        preSel,
  output logic              pwmOut
);

  pwm_strobe_t strb;
  logic        atLastPos;

  pwm_frac_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .en        (en),
    .preSel    (preSel),
    .atLastPos (atLastPos),
    .strb      (strb)
  );

  pwm_frac_datapath #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .periodIn  (periodIn),
    .dutyHiIn  (dutyHiIn),
    .dutyLoIn  (dutyLoIn),
    .atLastPos (atLastPos),
    .pwmOut    (pwmOut)
  );

endmodule

// File: rtl/pwm_frac_chk.sv
`timescale 1ns/1ps
module pwm_frac_chk
  import pwm_frac_pkg::*;
#(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rstN,
  input logic          en,
  input logic          pwmOut,
  input logic          atLastPos,
  input pwm_strobe_t   strb,
  input logic [DW-1:0] dutyWord
);

  // R8
  en_low_out_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !pwmOut);

  // R8
  en_low_counters_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !atLastPos);

  // R6
  start_goes_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.start && dutyWord != '0) |=> pwmOut);

  // R5
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.start && dutyWord == '0) |=> !pwmOut);

  // R3
  low_stays_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.start && !pwmOut) |=> !pwmOut);

  // R6
  rise_only_at_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> $past(strb.start));

  // R1
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.start, strb.adv, strb.clear}));

endmodule

bind pwm_frac_gen pwm_frac_chk #(.DW(TMR_W + FRAC_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .en        (en),
  .pwmOut    (pwmOut),
  .atLastPos (atLastPos),
  .strb      (strb),
  .dutyWord  ({dutyHiIn, dutyLoIn})
);

// File: tb/pwm_frac_gen_tb.sv
`timescale 1ns/1ps
module pwm_frac_gen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       en = 1'b0;
  logic [7:0] periodIn = '0;
  logic [7:0] dutyHiIn = '0;
  logic [1:0] dutyLoIn = '0;
  logic [1:0] preSel = '0;
  logic       pwmOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_frac_gen u_dut (
    .clk(clk), .rstN(rstN), .en(en), .periodIn(periodIn),
    .dutyHiIn(dutyHiIn), .dutyLoIn(dutyLoIn), .preSel(preSel), .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCfg(input int per, input int hi, input int lo, input int sel);
    periodIn = 8'(per); dutyHiIn = 8'(hi); dutyLoIn = 2'(lo); preSel = 2'(sel);
  endtask

  // Restart with a new setting; leaves the bench at the first sample after enable.
  task automatic restart(input int per, input int hi, input int lo, input int sel);
    @(negedge clk); en = 1'b0; setCfg(per, hi, lo, sel);
    @(negedge clk); en = 1'b1;
    @(negedge clk);
  endtask

  // Measure one period. If skipWait, the current sample is the first high one.
  task automatic measure(input bit skipWait, output int hiCnt, output int total);
    bit inHigh = 1'b1;
    bit prev;
    if (!skipWait) begin
      prev = pwmOut;
      for (int i = 0; i < 20000; i++) begin
        @(negedge clk);
        if (pwmOut && !prev) break;
        prev = pwmOut;
      end
    end
    hiCnt = 1; total = 1; prev = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (pwmOut && !prev) break;
      if (!pwmOut) inHigh = 1'b0;
      else if (inHigh) hiCnt++;
      total++;
      prev = pwmOut;
    end
  endtask

  task automatic t_reset();
    #1;
    check(pwmOut == 1'b0, "R9 reset output", int'(pwmOut), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(pwmOut == 1'b0, "R9 idle after reset", int'(pwmOut), 0);
  endtask

  task automatic t_quarter();
    int h, t;
    restart(9, 3, 1, 0);  // D=13, P=1
    check(pwmOut == 1'b1, "R6 high after enable", int'(pwmOut), 1);
    measure(1'b1, h, t);
    check(h == 13, "R3 quarter-step high time", h, 13);
    check(t == 40, "R1 period prescale 1", t, 40);
  endtask

  task automatic t_pre4();
    int h, t;
    restart(3, 1, 2, 1);  // D=6, P=4
    measure(1'b1, h, t);
    check(h == 24, "R2 high time prescale 4", h, 24);
    check(t == 64, "R2 period prescale 4", t, 64);
  endtask

  task automatic t_pre16();
    int h, t;
    restart(1, 1, 1, 3);  // D=5, P=16 via select 3
    measure(1'b1, h, t);
    check(h == 80, "R2 high time prescale 16", h, 80);
    check(t == 128, "R2 period prescale 16", t, 128);
    restart(1, 0, 3, 2);  // D=3, P=16 via select 2
    measure(1'b1, h, t);
    check(h == 48, "R2 select 2 high time", h, 48);
    check(t == 128, "R2 select 2 period", t, 128);
  endtask

  task automatic t_wide();
    int h, t;
    restart(249, 125, 0, 0);  // D=500 of 1000
    measure(1'b1, h, t);
    check(h == 500, "R3 half duty high time", h, 500);
    check(t == 1000, "R1 period byte 249", t, 1000);
  endtask

  task automatic t_full();
    int h, t;
    int lows = 0;
    restart(4, 4, 3, 0);  // D=19 of 20
    measure(1'b1, h, t);
    check(h == 19, "R4 one below full high time", h, 19);
    check(t == 20, "R4 one below full period", t, 20);
    restart(4, 5, 0, 0);  // D=20 == full
    for (int i = 0; i < 60; i++) begin
      if (!pwmOut) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R4 full duty never low", lows, 0);
    restart(4, 255, 3, 0);  // D=1023 far above
    lows = 0;
    for (int i = 0; i < 60; i++) begin
      if (!pwmOut) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R4 oversize duty never low", lows, 0);
  endtask

  task automatic t_zero();
    int highs = 0;
    restart(4, 0, 0, 0);
    for (int i = 0; i < 60; i++) begin
      if (pwmOut) highs++;
      @(negedge clk);
    end
    check(highs == 0, "R5 zero duty never high", highs, 0);
  endtask

  task automatic t_shadow();
    int h, t;
    bit inHigh = 1'b1;
    bit prev = 1'b1;
    restart(9, 3, 1, 0);  // D=13, 40 clocks
    h = 1; t = 1;
    for (int i = 0; i < 2000; i++) begin
      if (t == 3) setCfg(4, 2, 0, 0);  // D=8, 20 clocks
      @(negedge clk);
      if (pwmOut && !prev) break;
      if (!pwmOut) inHigh = 1'b0;
      else if (inHigh) h++;
      t++;
      prev = pwmOut;
    end
    check(h == 13, "R7 running period keeps duty", h, 13);
    check(t == 40, "R7 running period keeps length", t, 40);
    measure(1'b1, h, t);
    check(h == 8, "R7 new duty next period", h, 8);
    check(t == 20, "R7 new period next period", t, 20);
  endtask

  task automatic t_disable();
    int h, t;
    int highs = 0;
    restart(9, 3, 1, 0);
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(pwmOut == 1'b0, "R8 low after disable", int'(pwmOut), 0);
    for (int i = 0; i < 20; i++) begin
      if (pwmOut) highs++;
      @(negedge clk);
    end
    check(highs == 0, "R8 stays low while disabled", highs, 0);
    en = 1'b1;
    @(negedge clk);
    check(pwmOut == 1'b1, "R6 high after re-enable", int'(pwmOut), 1);
    measure(1'b1, h, t);
    check(h == 13 && t == 40, "R8 full first period after re-enable", t, 40);
  endtask

  initial begin
    t_reset();
    t_quarter();
    t_pre4();
    t_pre16();
    t_wide();
    t_full();
    t_zero();
    t_shadow();
    t_disable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule